// File: doc/BRIEF.md
# Aliasing Register Window Decoder

This block sits in front of a controller's register spaces and decides, for every incoming slave access, where the access should go. There are three targets: a configuration-register window, an address-translation register window, and the ordinary memory/BAR path. Each register window is 4 KB wide.

The windows are not matched on the raw address. The decoder first folds the address into a programmable power-of-two span, by taking the address modulo the span. It then compares the folded address against each window base, folded the same way. As a result, both windows reappear at every multiple of the span across the whole 64-bit map. If the span is programmed to all ones, the folding does nothing, and each window answers only at its absolute base address.

A small write port programs the span and the two bases. Each accepted request produces a registered route code and a target-local offset one cycle later, together with a valid flag.

Top module: `regwin_alias_decoder`

## Requirements
- R1: After reset, the span is 0x0100_0000, the configuration base is 0x0 and the translation base is 0x1000. After reset, rsp_valid is 0, rsp_route is 0 and rsp_offset is 0.
- R2: rsp_route encodes the target as 0 = memory/BAR, 1 = configuration window and 2 = translation window; the code 3 is never produced. The rsp_valid, rsp_route and rsp_offset signals update one clock after a request with req_valid high is sampled, and rsp_valid equals the req_valid of the previous cycle.
- R3: An access goes to the configuration window when (addr mod span) lies in [cfg_base mod span, +4096). Its offset is then addr mod 4096.
- R4: An access goes to the translation window under the same rule, using the translation base. Its offset is then addr mod 4096.
- R5: With span 0x0800_0000 and configuration base 0, the addresses 0x0, 0x0800_0000, 0x1000_0000, 0x1800_0000 and 0x2000_0000 all hit the configuration window.
- R6: With span 0x1000_0000 and configuration base 0, the addresses 0x1000_0000 and 0x2000_0000 hit the configuration window. The address 0x1800_0000 goes to memory.
- R7: With the span programmed to all ones, each window hits only at its absolute base. Mirror addresses such as 0x0100_0000 go to memory.
- R8: When both windows match the same access, the configuration window is chosen.
- R9: An access that matches no window goes to memory, and its offset is the full address.
- R10: A control write takes effect for requests presented on the cycle after the write. A request presented in the same cycle as the write is decoded with the old values.
- R11: cfg_wr_sel selects the register: 0 = span, 1 = configuration base, 2 = translation base. A write with select 3 changes nothing. Base writes discard address bits 11:0.
- R12: In a cycle without a request, rsp_valid goes low on the next clock, and rsp_route and rsp_offset keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_sel | input | 2 | Control register select |
| cfg_wr_data | input | 64 | Control register write value |
| req_valid | input | 1 | Access request valid |
| req_addr | input | 64 | Access address |
| rsp_valid | output | 1 | Decoded result valid |
| rsp_route | output | 2 | Target code |
| rsp_offset | output | 64 | Target-local offset |

## Verification
The address decode is exercised in four groups of addresses, one group for each span setting: the reset span, 128 MB, 256 MB and all ones. Each group mixes direct window hits, mirrored hits, near-miss addresses and a high 64-bit address.

The 128 MB and 256 MB groups tell a folding that uses the right mask from one that drops or keeps a bit too many, since 0x1800_0000 flips between hit and miss across them. The all-ones group tells true un-mirrored decode from residual aliasing.

Directed tests then overlap the two bases to expose the priority rule. They write a base in the same cycle as a request to pin down when a write becomes visible. They also show that select code 3 and idle cycles leave the decoder's state alone.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    ROUTE_MEM  = 2'd0,
    ROUTE_CFG  = 2'd1,
    ROUTE_XLAT = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    SEL_SPAN      = 2'd0,
    SEL_CFG_BASE  = 2'd1,
    SEL_XLAT_BASE = 2'd2,
    SEL_NONE      = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/regwin_ctrl_regs.sv
module regwin_ctrl_regs #(
  parameter int              ADDR_W    = 64,
  parameter int              WIN_OFF_W = 12,
  parameter logic [ADDR_W-1:0] SPAN_RST = 64'h0000_0000_0100_0000,
  parameter logic [ADDR_W-1:0] CFG_RST  = 64'h0,
  parameter logic [ADDR_W-1:0] XLAT_RST = 64'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] span_mask,
  output logic [ADDR_W-1:0] cfg_base,
  output logic [ADDR_W-1:0] xlat_base
);
  import regwin_pkg::*;

  localparam int TAG_W = ADDR_W - WIN_OFF_W;
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] span_q;
  logic [ADDR_W-1:0] aligned_data;

  // Bases are kept window-aligned; the low offset bits are not stored.
  assign aligned_data = {wr_data[ADDR_W-1:WIN_OFF_W], {WIN_OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      span_q    <= SPAN_RST;
      cfg_base  <= {CFG_RST[ADDR_W-1:WIN_OFF_W], {WIN_OFF_W{1'b0}}};
      xlat_base <= {XLAT_RST[ADDR_W-1:WIN_OFF_W], {WIN_OFF_W{1'b0}}};
    end else if (wr_en) begin
      case (csr_sel_e'(wr_sel))
        SEL_SPAN:      span_q    <= wr_data;
        SEL_CFG_BASE:  cfg_base  <= aligned_data;
        SEL_XLAT_BASE: xlat_base <= aligned_data;
        default:       ;
      endcase
    end
  end

  // An all-ones span means no folding at all.
  always_comb begin
    if (span_q == ALL_ONES) span_mask = ALL_ONES;
    else                    span_mask = span_q - {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  logic unused_tag;
  assign unused_tag = ^{TAG_W{1'b0}};
endmodule

// File: rtl/regwin_window_match.sv
module regwin_window_match #(
  parameter int ADDR_W    = 64,
  parameter int WIN_OFF_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] span_mask,
  input  logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WIN_OFF_W;
  localparam logic [ADDR_W-1:0] TAG_KEEP = {{TAG_W{1'b1}}, {WIN_OFF_W{1'b0}}};

  logic [ADDR_W-1:0] folded_addr;
  logic [ADDR_W-1:0] folded_base;

  assign folded_addr = addr & span_mask & TAG_KEEP;
  assign folded_base = base & span_mask & TAG_KEEP;
  assign hit         = (folded_addr == folded_base);
endmodule

// File: rtl/regwin_route_stage.sv
module regwin_route_stage #(
  parameter int ADDR_W    = 64,
  parameter int WIN_OFF_W = 12,
  parameter int NWIN      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NWIN-1:0]   in_hit,
  output logic              out_valid,
  output logic [1:0]        out_route,
  output logic [ADDR_W-1:0] out_offset
);
  import regwin_pkg::*;

  route_e            nxt_route;
  logic [ADDR_W-1:0] nxt_off;
  logic              found;

  // Lowest index wins; window i maps to route code i+1.
  always_comb begin
    nxt_route = ROUTE_MEM;
    nxt_off   = in_addr;
    found     = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (in_hit[i] && !found) begin
        found     = 1'b1;
        nxt_route = route_e'(2'(i + 1));
        nxt_off   = {{(ADDR_W-WIN_OFF_W){1'b0}}, in_addr[WIN_OFF_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_route  <= ROUTE_MEM;
      out_offset <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_route  <= nxt_route;
        out_offset <= nxt_off;
      end
    end
  end
endmodule

// File: rtl/regwin_alias_decoder.sv
module regwin_alias_decoder #(
  parameter int ADDR_W    = 64,
  parameter int WIN_OFF_W = 12,
  parameter logic [ADDR_W-1:0] SPAN_RST = 64'h0000_0000_0100_0000,
  parameter logic [ADDR_W-1:0] CFG_RST  = 64'h0,
  parameter logic [ADDR_W-1:0] XLAT_RST = 64'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_route,
  output logic [ADDR_W-1:0] rsp_offset
);
  localparam int NWIN = 2;

  logic [ADDR_W-1:0] span_mask;
  logic [ADDR_W-1:0] win_base [NWIN];
  logic [NWIN-1:0]   win_hit;

  regwin_ctrl_regs #(
    .ADDR_W(ADDR_W), .WIN_OFF_W(WIN_OFF_W),
    .SPAN_RST(SPAN_RST), .CFG_RST(CFG_RST), .XLAT_RST(XLAT_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .span_mask(span_mask), .cfg_base(win_base[0]), .xlat_base(win_base[1])
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    regwin_window_match #(.ADDR_W(ADDR_W), .WIN_OFF_W(WIN_OFF_W)) u_match (
      .addr(req_addr), .span_mask(span_mask), .base(win_base[w]), .hit(win_hit[w])
    );
  end

  regwin_route_stage #(.ADDR_W(ADDR_W), .WIN_OFF_W(WIN_OFF_W), .NWIN(NWIN)) u_route (
    .clk(clk), .rst(rst),
    .in_valid(req_valid), .in_addr(req_addr), .in_hit(win_hit),
    .out_valid(rsp_valid), .out_route(rsp_route), .out_offset(rsp_offset)
  );
endmodule

// File: rtl/regwin_alias_decoder_chk.sv
module regwin_alias_decoder_chk #(
  parameter int ADDR_W    = 64,
  parameter int WIN_OFF_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [1:0]        rsp_route,
  input logic [ADDR_W-1:0] rsp_offset
);
  localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-WIN_OFF_W){1'b0}}, {WIN_OFF_W{1'b1}}};

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r12_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_route) && $stable(rsp_offset)));

  a_r9_mem_offset: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_route != 2'd0 || rsp_offset == $past(req_addr)));

  a_r3_win_offset: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_route == 2'd0 || rsp_offset == ($past(req_addr) & LOW_MASK)));

  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    rsp_route != 2'd3);
endmodule

bind regwin_alias_decoder regwin_alias_decoder_chk #(
  .ADDR_W(ADDR_W), .WIN_OFF_W(WIN_OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_offset(rsp_offset)
);

// File: tb/sim_regwin_alias_decoder.sv
module sim_regwin_alias_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = '0;
  logic [63:0] cfg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_route;
  logic [63:0] rsp_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regwin_alias_decoder u0 (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_offset(rsp_offset)
  );

  localparam logic [63:0] S16  = 64'h0100_0000;
  localparam logic [63:0] S128 = 64'h0800_0000;
  localparam logic [63:0] S256 = 64'h1000_0000;
  localparam logic [63:0] SONE = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 19;
  localparam logic [63:0] V_SPAN [NV] = '{
    S16, S16, S16, S16, S16, S16,
    S128, S128, S128, S128, S128,
    S256, S256, S256, S256,
    SONE, SONE, SONE, SONE};
  localparam logic [63:0] V_ADDR [NV] = '{
    64'h0000_0010, 64'h0000_1ABC, 64'h0000_2000, 64'h0100_1008, 64'h0300_0FF8,
    64'hFFFF_FFFF_FF00_1234,
    64'h0, 64'h0800_0000, 64'h1000_0004, 64'h1800_0000, 64'h2000_0000,
    64'h1000_0000, 64'h2000_0000, 64'h1800_0000, 64'h1800_1000,
    64'h0000_0100, 64'h0100_0000, 64'h0000_1004, 64'hF000_0000_0000_0000};
  // route codes: 0 memory, 1 configuration, 2 translation
  localparam logic [1:0] V_ROUTE [NV] = '{
    2'd1, 2'd2, 2'd0, 2'd2, 2'd1, 2'd2,
    2'd1, 2'd1, 2'd1, 2'd1, 2'd1,
    2'd1, 2'd1, 2'd0, 2'd0,
    2'd1, 2'd0, 2'd2, 2'd0};
  localparam string V_REQ [NV] = '{
    "R3", "R4", "R9", "R4", "R3", "R4",
    "R5", "R5", "R5", "R5", "R5",
    "R6", "R6", "R6", "R6",
    "R7", "R7", "R7", "R7"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic req(input logic [63:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_route(input string r, input logic [63:0] addr, input logic [1:0] route);
    check(r, {63'd0, rsp_valid}, 64'd1);
    check(r, {62'd0, rsp_route}, {62'd0, route});
    check(r, rsp_offset, (route == 2'd0) ? addr : (addr & 64'hFFF));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] cur_span;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset outputs
    check("R1", {63'd0, rsp_valid}, 64'd0);
    check("R1", {62'd0, rsp_route}, 64'd0);
    check("R1", rsp_offset, 64'd0);

    cur_span = S16;
    for (int i = 0; i < NV; i++) begin
      if (V_SPAN[i] != cur_span) begin
        wr(2'd0, V_SPAN[i]);
        cur_span = V_SPAN[i];
      end
      req(V_ADDR[i]);
      expect_route(V_REQ[i], V_ADDR[i], V_ROUTE[i]);
    end

    // R12: idle cycle leaves route/offset alone (last was memory at 0xF000...)
    @(negedge clk);
    check("R12", {63'd0, rsp_valid}, 64'd0);
    check("R12", {62'd0, rsp_route}, 64'd0);
    check("R12", rsp_offset, 64'hF000_0000_0000_0000);

    // R11: base write drops bits 11:0 (span still all ones)
    wr(2'd1, 64'h1800_0ABC);
    req(64'h1800_0123);
    expect_route("R11", 64'h1800_0123, 2'd1);
    req(64'h0000_0040);
    expect_route("R11", 64'h0000_0040, 2'd0);

    // R8: both windows on the same base -> configuration wins
    wr(2'd2, 64'h1800_0000);
    req(64'h1800_0FFF);
    expect_route("R8", 64'h1800_0FFF, 2'd1);

    // R11: select 3 changes no register
    wr(2'd3, 64'h4000_0000);
    req(64'h1800_0123);
    expect_route("R11", 64'h1800_0123, 2'd1);
    req(64'h4000_0000);
    expect_route("R11", 64'h4000_0000, 2'd0);

    // R10: write and request in the same cycle use old values
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 2'd1; cfg_wr_data = 64'h2000_0000;
    req_valid = 1'b1; req_addr = 64'h1800_0010;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    expect_route("R10", 64'h1800_0010, 2'd1);
    req(64'h1800_0010);
    expect_route("R10", 64'h1800_0010, 2'd2);
    req(64'h2000_0010);
    expect_route("R10", 64'h2000_0010, 2'd1);

    // R1: reset restores default span and bases
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", {63'd0, rsp_valid}, 64'd0);
    check("R1", {62'd0, rsp_route}, 64'd0);
    req(64'h0500_1000);
    expect_route("R1", 64'h0500_1000, 2'd2);
    req(64'h0500_0000);
    expect_route("R1", 64'h0500_0000, 2'd1);

    finish_run();
  end
endmodule